// File: doc/BRIEF.md
# Byte-addressed register bank with AXI4-Lite access

This block is an AXI4-Lite slave that holds a small register bank with a fixed layout. It turns byte addresses into register slots and answers single reads and writes. The first two slots are identity words that are always present. One is a version word and the other is an identifier constant. After them come a status word that follows a hardware input, a scratch word that software can write and that drives a hardware output, and a control word. The control word carries a 2-bit baud-select code.

Slots lie at consecutive offsets, one data-width step apart, counted from a base address. An address that is misaligned, that lies below the base or that lies past the last slot hits no register. Reads of such an address return a filler value set by a parameter, and writes to it have no effect. Parameters set the data width (32 or 64), the address width, the base address, the filler value and the reset style. The reset style chooses synchronous or asynchronous reset and active-high or active-low polarity.

Top module: `regmap_axil_slave`

## Requirements
- R1: After reset, awready, wready and arready are 1, bvalid and rvalid are 0, scratch_out is 0 and baud_sel is 0. The version slot reads 0x03010000: major 3 in bits 31:24, minor 1 in bits 23:16, patch 0 in bits 15:8 and revision 0 in bits 7:0. The identifier slot reads 32.
- R2: Slots sit at BASE_ADDR + k*(DATA_W/8) in this order: k=0 version, k=1 identifier, k=2 status, k=3 scratch, k=4 control.
- R3: An address below BASE_ADDR, not a multiple of DATA_W/8 above it, or beyond slot 4 reads as READ_FILL. A write to such an address changes no register.
- R4: A read of the status slot returns the value that hw_status had in the cycle of the read-address handshake.
- R5: A write to the scratch slot updates byte lane k (bits 8k+7:8k) only when wstrb[k] is 1. scratch_out always equals the stored scratch word, and the scratch slot reads it back.
- R6: In the control slot, bits 1:0 hold the baud code: 0 means 9600, 1 means 38400, 2 means 115200 and 3 is reserved. A write with wstrb[0]=1 and code 0 to 2 stores the code. A write of code 3, or a write with wstrb[0]=0, leaves the field unchanged. Bits above 1 read 0, and baud_sel drives the field.
- R7: Writes to the version, identifier and status slots change nothing that can be read.
- R8: Write address and write data are accepted in either order. A write takes effect only when both have arrived. Each write gives exactly one response, and bvalid stays high until bready.
- R9: Only one read and one write can be in flight at a time. Once a write channel has been accepted, its ready stays low until the write response handshake. arready is low while rvalid is high, and rdata holds steady until rready.
- R10: Every response carries OKAY (bresp = rresp = 0), including responses to unmapped addresses.
- R11: RST_MODE chooses the reset style: 0 synchronous active-high, 1 synchronous active-low (the default), 2 asynchronous active-high, 3 asynchronous active-low. Asserting reset at any time restores the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, polarity and timing set by RST_MODE |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| hw_status | input | DATA_W | Value shown in the status slot |
| scratch_out | output | DATA_W | Current scratch word |
| baud_sel | output | 2 | Current baud code |

## Verification
The assertions assume that the master keeps to AXI handshake rules. A valid, once raised, stays high until its handshake, and address, data and strobes do not change while valid is high. The response ready signals may rise or fall at any time. The bench drives every field at the falling edge, keeps each valid high until it sees ready sampled high, and drops the valid right after the handshake edge. It also holds bready and rready low for a random number of cycles, so the hold properties are exercised. hw_status is unconstrained, and the bench changes it while a read response is pending.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    typedef enum logic [1:0] {
        RST_SYNC_HI  = 2'd0,
        RST_SYNC_LO  = 2'd1,
        RST_ASYNC_HI = 2'd2,
        RST_ASYNC_LO = 2'd3
    } rst_mode_e;

    typedef enum logic [1:0] {
        BAUD_9600   = 2'd0,
        BAUD_38400  = 2'd1,
        BAUD_115200 = 2'd2,
        BAUD_RSVD   = 2'd3
    } baud_e;

    // slot order is behaviour: it fixes each register's offset
    typedef enum logic [2:0] {
        SLOT_VERSION = 3'd0,
        SLOT_IDENT   = 3'd1,
        SLOT_STATUS  = 3'd2,
        SLOT_SCRATCH = 3'd3,
        SLOT_CTRL    = 3'd4
    } slot_e;

    localparam int          NUM_SLOTS   = 5;
    localparam logic [7:0]  VER_MAJOR   = 8'd3;
    localparam logic [7:0]  VER_MINOR   = 8'd1;
    localparam logic [7:0]  VER_PATCH   = 8'd0;
    localparam logic [7:0]  VER_REV     = 8'd0;
    localparam logic [31:0] IDENT_VALUE = 32'd32;

endpackage

// File: rtl/regmap_wr_chan.sv
module regmap_wr_chan #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter bit ASYNC  = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic                bvalid,
    input  logic                bready,
    output logic                commit,
    output logic [ADDR_W-1:0]   cm_addr,
    output logic [DATA_W-1:0]   cm_data,
    output logic [DATA_W/8-1:0] cm_strb
);
    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic              aw_held;
        logic              w_held;
        logic              b_pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_state_t;

    localparam wr_state_t WR_RESET = '0;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        awready = !st_q.aw_held && !st_q.b_pend;
        wready  = !st_q.w_held && !st_q.b_pend;
        commit  = st_q.aw_held && st_q.w_held;
        if (awvalid && awready) begin
            st_d.aw_held = 1'b1;
            st_d.addr    = awaddr;
        end
        if (wvalid && wready) begin
            st_d.w_held = 1'b1;
            st_d.data   = wdata;
            st_d.strb   = wstrb;
        end
        if (commit) begin
            st_d.aw_held = 1'b0;
            st_d.w_held  = 1'b0;
            st_d.b_pend  = 1'b1;
        end
        if (st_q.b_pend && bready) begin
            st_d.b_pend = 1'b0;
        end
    end

    generate
        if (ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) st_q <= WR_RESET;
                else     st_q <= st_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) st_q <= WR_RESET;
                else     st_q <= st_d;
            end
        end
    endgenerate

    assign bvalid  = st_q.b_pend;
    assign cm_addr = st_q.addr;
    assign cm_data = st_q.data;
    assign cm_strb = st_q.strb;

    // R8: a pending response waits for its ready
    a_r8_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);
    // R8: a commit always produces a response in the next cycle
    a_r8_commit_resp: assert property (@(posedge clk) disable iff (rst)
        commit |=> bvalid);
    // R9: no new write accepted while a response is pending
    a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> !awready && !wready);

endmodule

// File: rtl/regmap_rd_chan.sv
module regmap_rd_chan #(
    parameter int DATA_W = 32,
    parameter bit ASYNC  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    input  logic [DATA_W-1:0] lk_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready
);
    typedef struct packed {
        logic              r_pend;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    localparam rd_state_t RD_RESET = '0;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        arready = !st_q.r_pend;
        if (arvalid && arready) begin
            st_d.r_pend = 1'b1;
            st_d.data   = lk_data;
        end
        if (st_q.r_pend && rready) begin
            st_d.r_pend = 1'b0;
        end
    end

    generate
        if (ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) st_q <= RD_RESET;
                else     st_q <= st_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) st_q <= RD_RESET;
                else     st_q <= st_d;
            end
        end
    endgenerate

    assign rvalid = st_q.r_pend;
    assign rdata  = st_q.data;

    // R9: read data stays put until accepted
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));
    // R9: only one read in flight
    a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);

endmodule

// File: rtl/regmap_regs.sv
module regmap_regs
    import regmap_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [DATA_W-1:0] READ_FILL = '0,
    parameter bit                ASYNC     = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   w_addr,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic [ADDR_W-1:0]   r_addr,
    output logic [DATA_W-1:0]   r_data,
    input  logic [DATA_W-1:0]   hw_status,
    output logic [DATA_W-1:0]   scratch_out,
    output logic [1:0]          baud_sel
);
    localparam int STRB_W    = DATA_W / 8;
    localparam int ALIGN_LSB = $clog2(STRB_W);
    localparam logic [DATA_W-1:0] VERSION_WORD =
        DATA_W'({VER_MAJOR, VER_MINOR, VER_PATCH, VER_REV});
    localparam logic [DATA_W-1:0] IDENT_WORD = DATA_W'(IDENT_VALUE);

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [1:0]        baud;
    } reg_state_t;

    localparam reg_state_t REG_RESET = '{scratch: '0, baud: BAUD_9600};

    reg_state_t st_d, st_q;
    dec_t       wdec, rdec;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t              r;
        logic [ADDR_W-1:0] off;
        off   = a - BASE_ADDR;
        r.idx = off >> ALIGN_LSB;
        r.hit = (a >= BASE_ADDR) && (off[ALIGN_LSB-1:0] == '0)
                && (r.idx < ADDR_W'(NUM_SLOTS));
        return r;
    endfunction

    always_comb begin
        wdec = decode(w_addr);
        st_d = st_q;
        if (we && wdec.hit) begin
            if (wdec.idx == ADDR_W'(SLOT_SCRATCH)) begin
                for (int k = 0; k < STRB_W; k++) begin
                    if (w_strb[k]) st_d.scratch[8*k +: 8] = w_data[8*k +: 8];
                end
            end
            if (wdec.idx == ADDR_W'(SLOT_CTRL) && w_strb[0]
                && w_data[1:0] != BAUD_RSVD) begin
                st_d.baud = w_data[1:0];
            end
        end
    end

    always_comb begin
        rdec   = decode(r_addr);
        r_data = READ_FILL;
        if (rdec.hit) begin
            case (rdec.idx)
                ADDR_W'(SLOT_VERSION): r_data = VERSION_WORD;
                ADDR_W'(SLOT_IDENT):   r_data = IDENT_WORD;
                ADDR_W'(SLOT_STATUS):  r_data = hw_status;
                ADDR_W'(SLOT_SCRATCH): r_data = st_q.scratch;
                default:               r_data = DATA_W'(st_q.baud);
            endcase
        end
    end

    generate
        if (ASYNC) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) st_q <= REG_RESET;
                else     st_q <= st_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) st_q <= REG_RESET;
                else     st_q <= st_d;
            end
        end
    endgenerate

    assign scratch_out = st_q.scratch;
    assign baud_sel    = st_q.baud;

    // R6: the reserved code never reaches the output
    a_r6_baud_not_reserved: assert property (@(posedge clk) disable iff (rst)
        baud_sel != BAUD_RSVD);
    // R5: the scratch word moves only on a committed write
    a_r5_scratch_quiet: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(scratch_out));
    // R6: the baud code moves only on a committed write
    a_r6_baud_quiet: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(baud_sel));

endmodule

// File: rtl/regmap_axil_slave.sv
module regmap_axil_slave
    import regmap_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [DATA_W-1:0] READ_FILL = '0,
    parameter rst_mode_e         RST_MODE  = RST_SYNC_LO
) (
    input  logic                clk,
    input  logic                rst_in,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    input  logic [DATA_W-1:0]   hw_status,
    output logic [DATA_W-1:0]   scratch_out,
    output logic [1:0]          baud_sel
);
    localparam int STRB_W = DATA_W / 8;
    localparam bit ASYNC  = (RST_MODE == RST_ASYNC_HI) || (RST_MODE == RST_ASYNC_LO);
    localparam bit ACT_LO = (RST_MODE == RST_SYNC_LO)  || (RST_MODE == RST_ASYNC_LO);

    logic              rst;
    logic              commit;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_data;
    logic [STRB_W-1:0] cm_strb;
    logic [DATA_W-1:0] lk_data;

    assign rst     = ACT_LO ? ~rst_in : rst_in;
    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    regmap_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASYNC(ASYNC)) u_wr (
        .clk(clk), .rst(rst),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .commit(commit), .cm_addr(cm_addr), .cm_data(cm_data), .cm_strb(cm_strb)
    );

    regmap_rd_chan #(.DATA_W(DATA_W), .ASYNC(ASYNC)) u_rd (
        .clk(clk), .rst(rst),
        .arvalid(s_arvalid), .arready(s_arready), .lk_data(lk_data),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready)
    );

    regmap_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
        .READ_FILL(READ_FILL), .ASYNC(ASYNC)
    ) u_regs (
        .clk(clk), .rst(rst),
        .we(commit), .w_addr(cm_addr), .w_data(cm_data), .w_strb(cm_strb),
        .r_addr(s_araddr), .r_data(lk_data), .hw_status(hw_status),
        .scratch_out(scratch_out), .baud_sel(baud_sel)
    );

endmodule

// File: tb/regmap_axil_slave_tb.sv
module regmap_axil_slave_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [9:0]  BASE       = 10'h100;
    localparam logic [31:0] FILL       = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [9:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic [31:0] hw_status = '0;
    logic [31:0] scratch_out;
    logic [1:0]  baud_sel;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] m_scratch = '0;
    logic [1:0]  m_baud = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regmap_axil_slave #(
        .DATA_W(32), .ADDR_W(10), .BASE_ADDR(BASE), .READ_FILL(FILL)
    ) u_dut (
        .clk(clk), .rst_in(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .hw_status(hw_status), .scratch_out(scratch_out), .baud_sel(baud_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [9:0] a);
        logic [9:0] off;
        if (a < BASE) return -1;
        off = a - BASE;
        if (off[1:0] != 2'b00) return -1;
        if ((off >> 2) > 10'd4) return -1;
        return int'(off >> 2);
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        case (slot_of(a))
            0:       return 32'h0301_0000;
            1:       return 32'd32;
            2:       return hw_status;
            3:       return m_scratch;
            4:       return {30'd0, m_baud};
            default: return FILL;
        endcase
    endfunction

    function automatic void model_write(input logic [9:0] a, input logic [31:0] d,
                                        input logic [3:0] s);
        if (slot_of(a) == 3) begin
            for (int k = 0; k < 4; k++) if (s[k]) m_scratch[8*k +: 8] = d[8*k +: 8];
        end
        if (slot_of(a) == 4 && s[0] && d[1:0] != 2'd3) m_baud = d[1:0];
    endfunction

    // order: 0 together, 1 address first, 2 data first
    task automatic do_write(input logic [9:0] a, input logic [31:0] d,
                            input logic [3:0] s, input int order);
        bit aw_done = 1'b0;
        bit w_done  = 1'b0;
        int hold;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        if (order == 1) begin
            awvalid = 1'b1;
            while (!aw_done) begin
                if (awready) aw_done = 1'b1;
                @(negedge clk);
            end
            awvalid = 1'b0;
            repeat (2) @(negedge clk);
            chk(!bvalid, "R8", "no response before data", 32'(bvalid), 32'd0);
            chk(!awready, "R9", "awready low while address held", 32'(awready), 32'd0);
        end else if (order == 2) begin
            wvalid = 1'b1;
            while (!w_done) begin
                if (wready) w_done = 1'b1;
                @(negedge clk);
            end
            wvalid = 1'b0;
            repeat (2) @(negedge clk);
            chk(!bvalid, "R8", "no response before address", 32'(bvalid), 32'd0);
            chk(!wready, "R9", "wready low while data held", 32'(wready), 32'd0);
        end
        awvalid = !aw_done;
        wvalid  = !w_done;
        while (!(aw_done && w_done)) begin
            if (awvalid && awready) aw_done = 1'b1;
            if (wvalid && wready)   w_done  = 1'b1;
            @(negedge clk);
            if (aw_done) awvalid = 1'b0;
            if (w_done)  wvalid  = 1'b0;
        end
        while (!bvalid) @(negedge clk);
        chk(bresp == 2'b00, "R10", "bresp OKAY", 32'(bresp), 32'd0);
        hold = $urandom % 3;
        repeat (hold) begin
            @(negedge clk);
            chk(bvalid, "R8", "bvalid held until bready", 32'(bvalid), 32'd1);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk(!bvalid, "R8", "single write response", 32'(bvalid), 32'd0);
        model_write(a, d, s);
        chk(scratch_out == m_scratch, "R5", "scratch_out", scratch_out, m_scratch);
        chk(baud_sel == m_baud, "R6", "baud_sel", 32'(baud_sel), 32'(m_baud));
    endtask

    task automatic do_read(input logic [9:0] a, input bit perturb,
                           input string req);
        bit          done = 1'b0;
        logic [31:0] exp;
        logic [31:0] got;
        int          hold;
        @(negedge clk);
        araddr  = a;
        arvalid = 1'b1;
        exp     = exp_read(a);
        while (!done) begin
            if (arready) done = 1'b1;
            @(negedge clk);
        end
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        got = rdata;
        chk(got == exp, req, $sformatf("read data at %h", a), got, exp);
        chk(rresp == 2'b00, "R10", "rresp OKAY", 32'(rresp), 32'd0);
        chk(!arready, "R9", "arready low while rvalid", 32'(arready), 32'd0);
        if (perturb) hw_status = $urandom;
        hold = $urandom % 3;
        repeat (hold) begin
            @(negedge clk);
            chk(rvalid && rdata == got, "R9", "rdata held until rready", rdata, got);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic check_reset_state(input string req);
        chk(awready && wready && arready, req, "readies after reset",
            {29'd0, awready, wready, arready}, 32'd7);
        chk(!bvalid && !rvalid, req, "valids after reset",
            {30'd0, bvalid, rvalid}, 32'd0);
        chk(scratch_out == 32'd0, req, "scratch_out after reset", scratch_out, 32'd0);
        chk(baud_sel == 2'd0, req, "baud_sel after reset", 32'(baud_sel), 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1");

        // R1 R2: identity and layout
        do_read(BASE + 10'd0,  1'b0, "R1");
        do_read(BASE + 10'd4,  1'b0, "R2");
        do_read(BASE + 10'd16, 1'b0, "R2");

        // R5: full and partial strobes
        do_write(BASE + 10'd12, 32'hA5A5_1234, 4'hF, 0);
        do_read(BASE + 10'd12, 1'b0, "R5");
        do_write(BASE + 10'd12, 32'h1122_3344, 4'b0101, 0);
        do_read(BASE + 10'd12, 1'b0, "R5");

        // R7 R8: read-only slots, either channel order
        do_write(BASE + 10'd0, 32'hFFFF_FFFF, 4'hF, 1);
        do_read(BASE + 10'd0, 1'b0, "R7");
        do_write(BASE + 10'd4, 32'h0, 4'hF, 2);
        do_read(BASE + 10'd4, 1'b0, "R7");
        hw_status = 32'hCAFE_0001;
        do_write(BASE + 10'd8, 32'h0, 4'hF, 1);
        do_read(BASE + 10'd8, 1'b1, "R4");

        // R6: baud code, reserved code, strobe off
        do_write(BASE + 10'd16, 32'hFFFF_FFF2, 4'hF, 0);
        do_read(BASE + 10'd16, 1'b0, "R6");
        do_write(BASE + 10'd16, 32'h0000_0003, 4'hF, 2);
        do_read(BASE + 10'd16, 1'b0, "R6");
        do_write(BASE + 10'd16, 32'h0000_0001, 4'b1110, 1);
        do_read(BASE + 10'd16, 1'b0, "R6");
        do_write(BASE + 10'd16, 32'h0000_0001, 4'b0001, 0);
        do_read(BASE + 10'd16, 1'b0, "R6");

        // R3: below base, misaligned, beyond the last slot
        do_read(BASE - 10'd4,  1'b0, "R3");
        do_read(BASE + 10'd13, 1'b0, "R3");
        do_read(BASE + 10'd20, 1'b0, "R3");
        do_write(BASE + 10'd13, 32'h0BAD_0BAD, 4'hF, 0);
        do_write(BASE + 10'd17, 32'h0000_0002, 4'hF, 0);
        do_write(BASE - 10'd4,  32'h0000_0002, 4'hF, 0);
        do_read(BASE + 10'd12, 1'b0, "R3");
        do_read(BASE + 10'd16, 1'b0, "R3");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [9:0] a;
            if (($urandom % 10) < 7) a = BASE + 10'(4 * ($urandom % 5));
            else                     a = 10'($urandom);
            hw_status = $urandom;
            if ($urandom % 2) do_write(a, $urandom, 4'($urandom), int'($urandom % 3));
            else              do_read(a, 1'($urandom), "R2");
        end

        // R11: synchronous active-low reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_scratch = '0;
        m_baud    = '0;
        @(negedge clk);
        check_reset_state("R11");
        do_read(BASE + 10'd12, 1'b0, "R11");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule